// File: doc/BRIEF.md
# Unipolar Line-Code Encoder

This block turns a stream of data bits into a single-wire unipolar waveform, one bit per bit period. Each bit period is divided into a fixed number of sub-slots. A sub-slot clock enable advances the period, so the bit rate is set by how often that enable fires. Six encodings can be chosen at run time. Three are level-based: plain level, mark-toggle and space-toggle. Three are pulse-shaped: return-to-zero, pulse-position and pulse-duration.

A producer watches the bit-request pulse and presents a bit together with the accept strobe in that same clock. The block samples the bit and the scheme select on that edge. The bit is then driven on the line for the whole of the following period, and a one-clock period-start marker flags the first clock of that period. A running line level is kept for the two toggle schemes. If the producer has no bit ready, a zero is encoded and a sticky underrun flag is raised.

Top module: `ucode_tx`

## Requirements
- R1: After reset, line_out, period_start and underrun are low, the toggle-scheme line state is low, and the first slot_en clock raises bit_req.
- R2: Scheme code 0 (level) drives the line high for a 1 and low for a 0 in all four sub-slots of the period.
- R3: Scheme code 1 (mark) inverts the held line state at the start of a period carrying a 1, and keeps it for a 0. The line follows the state for the whole period.
- R4: Scheme code 2 (space) inverts the held line state at the start of a period carrying a 0, and keeps it for a 1.
- R5: Scheme code 3 (return-to-zero) drives a 1 high in sub-slots 0 and 1 and low in sub-slots 2 and 3. A 0 is low throughout.
- R6: Scheme code 4 (pulse-position) drives a 0 high only in sub-slot 0 and a 1 high only in sub-slot 2.
- R7: Scheme code 5 (pulse-duration) drives a 0 high only in sub-slot 0 and a 1 high in sub-slots 0 to 2.
- R8: Scheme codes 6 and 7 are reserved and hold the line low.
- R9: bit_req is high exactly in the clocks where slot_en is high and the last sub-slot (3) is current. data_bit, data_valid and mode_sel are sampled on that edge, and period_start is high for the single following clock.
- R10: If data_valid is low when bit_req is high, a 0 is encoded and underrun goes high and stays high until reset.
- R11: The toggle-scheme line state survives periods coded in other schemes and resumes from its last value when a toggle scheme returns.
- R12: line_out changes only on clock edges where slot_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Sub-slot enable; one high clock per sub-slot |
| mode_sel | input | 3 | Scheme select, sampled at the bit request |
| data_bit | input | 1 | Data bit offered to the encoder |
| data_valid | input | 1 | Accept strobe: data_bit is valid this clock |
| line_out | output | 1 | Encoded unipolar line level (registered) |
| bit_req | output | 1 | Request for the next bit |
| period_start | output | 1 | One-clock marker on the first clock of a bit period |
| underrun | output | 1 | Sticky flag: a requested bit was missing |

## Verification
Each scheme first runs alone on random bits with slot_en high every clock. This separates the level schemes from the pulse schemes sub-slot by sub-slot, and it shows whether the toggle schemes invert on the right bit value. Next, the scheme changes at random at each bit while slot_en fires irregularly. This shows whether the toggle state carries across foreign schemes and whether the line ever moves between enables. A last phase withholds data_valid at random to exercise the forced zero and the sticky underrun flag. A reset in mid-run then shows the flag clearing.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  typedef enum logic [2:0] {
    LC_LEVEL = 3'd0,
    LC_MARK  = 3'd1,
    LC_SPACE = 3'd2,
    LC_RZ    = 3'd3,
    LC_PPOS  = 3'd4,
    LC_PDUR  = 3'd5,
    LC_RSV6  = 3'd6,
    LC_RSV7  = 3'd7
  } lc_mode_e;
endpackage

// File: rtl/ucode_slot_seq.sv
// Sub-slot sequencer: counts slots within a bit period and flags the wrap.
module ucode_slot_seq #(
  parameter int SLOTS = 4,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_en,
  output logic [SW-1:0] slot_q,
  output logic [SW-1:0] slot_nxt,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  assign wrap     = slot_en && (slot_q == LAST);
  assign slot_nxt = wrap ? '0 : (slot_en ? slot_q + 1'b1 : slot_q);

  // Reset parks the counter on the last slot so the first enable requests a bit.
  always_ff @(posedge clk) begin
    if (rst) slot_q <= LAST;
    else     slot_q <= slot_nxt;
  end
endmodule

// File: rtl/ucode_bit_latch.sv
// Samples bit and scheme at the period wrap; keeps the toggle-scheme line state.
module ucode_bit_latch
  import ucode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wrap,
  input  logic     data_bit,
  input  logic     data_valid,
  input  logic [2:0] mode_sel,
  output logic     cur_bit,
  output lc_mode_e cur_mode,
  output logic     nrz_q,
  output logic     nxt_bit,
  output lc_mode_e nxt_mode,
  output logic     nxt_nrz,
  output logic     underrun
);
  logic     take_bit;
  lc_mode_e sel_mode;
  logic     flip;

  assign take_bit = data_valid & data_bit;
  assign sel_mode = lc_mode_e'(mode_sel);

  always_comb begin
    flip = 1'b0;
    if (sel_mode == LC_MARK  &&  take_bit) flip = 1'b1;
    if (sel_mode == LC_SPACE && !take_bit) flip = 1'b1;
  end

  assign nxt_bit  = wrap ? take_bit : cur_bit;
  assign nxt_mode = wrap ? sel_mode : cur_mode;
  assign nxt_nrz  = (wrap && flip) ? ~nrz_q : nrz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_bit  <= 1'b0;
      cur_mode <= LC_LEVEL;
      nrz_q    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      cur_bit  <= nxt_bit;
      cur_mode <= nxt_mode;
      nrz_q    <= nxt_nrz;
      if (wrap && !data_valid) underrun <= 1'b1;
    end
  end

  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  assert_nrz_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(wrap) |-> $stable(nrz_q));
endmodule

// File: rtl/ucode_shaper.sv
// Combinational waveform shaper: line level for a given slot, bit and scheme.
module ucode_shaper
  import ucode_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int SHORT   = 1,
  parameter int LONG    = 3,
  parameter int PPM_POS = 2,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int HALF = SLOTS / 2
) (
  input  logic [SW-1:0] slot,
  input  logic          bit_v,
  input  lc_mode_e      mode,
  input  logic          nrz,
  output logic          level
);
  int s;
  assign s = int'(slot);

  always_comb begin
    case (mode)
      LC_LEVEL: level = bit_v;
      LC_MARK,
      LC_SPACE: level = nrz;
      LC_RZ:    level = bit_v && (s < HALF);
      LC_PPOS:  level = bit_v ? ((s >= PPM_POS) && (s < PPM_POS + SHORT))
                              : (s < SHORT);
      LC_PDUR:  level = bit_v ? (s < LONG) : (s < SHORT);
      default:  level = 1'b0;
    endcase
  end
endmodule

// File: rtl/ucode_tx.sv
// Unipolar line-code encoder top.
module ucode_tx
  import ucode_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int SHORT   = 1,
  parameter int LONG    = 3,
  parameter int PPM_POS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slot_en,
  input  logic [2:0] mode_sel,
  input  logic       data_bit,
  input  logic       data_valid,
  output logic       line_out,
  output logic       bit_req,
  output logic       period_start,
  output logic       underrun
);
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int HALF = SLOTS / 2;

  logic [SW-1:0] slot_q, slot_nxt;
  logic          wrap;
  logic          cur_bit, nrz_q, nxt_bit, nxt_nrz;
  lc_mode_e      cur_mode, nxt_mode;
  logic          level_nxt;
  logic          line_q, pstart_q;

  ucode_slot_seq #(.SLOTS(SLOTS)) u_seq (
    .clk(clk), .rst(rst), .slot_en(slot_en),
    .slot_q(slot_q), .slot_nxt(slot_nxt), .wrap(wrap)
  );

  ucode_bit_latch u_latch (
    .clk(clk), .rst(rst), .wrap(wrap),
    .data_bit(data_bit), .data_valid(data_valid), .mode_sel(mode_sel),
    .cur_bit(cur_bit), .cur_mode(cur_mode), .nrz_q(nrz_q),
    .nxt_bit(nxt_bit), .nxt_mode(nxt_mode), .nxt_nrz(nxt_nrz),
    .underrun(underrun)
  );

  ucode_shaper #(.SLOTS(SLOTS), .SHORT(SHORT), .LONG(LONG), .PPM_POS(PPM_POS)) u_shape (
    .slot(slot_nxt), .bit_v(nxt_bit), .mode(nxt_mode), .nrz(nxt_nrz),
    .level(level_nxt)
  );

  // Line and marker are registered; the line is refreshed once per sub-slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= 1'b0;
      pstart_q <= 1'b0;
    end else begin
      pstart_q <= wrap;
      if (slot_en) line_q <= level_nxt;
    end
  end

  assign line_out     = line_q;
  assign period_start = pstart_q;
  assign bit_req      = wrap;

  assert_start_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
    period_start |-> $past(bit_req));

  assert_rz_second_half_low_R5: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == LC_RZ && int'(slot_q) >= HALF) |-> !line_out);

  assert_pdur_first_slot_high_R7: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == LC_PDUR && slot_q == '0) |-> line_out);

  assert_reserved_low_R8: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == LC_RSV6 || cur_mode == LC_RSV7) |-> !line_out);

  assert_line_on_enable_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(slot_en) && !$past(rst) |-> $stable(line_out));
endmodule

// File: tb/ucode_tx_bench.sv
module ucode_tx_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_en = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic data_bit = 1'b0;
  logic data_valid = 1'b0;
  logic line_out, bit_req, period_start, underrun;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Reference model state
  int m_slot = 3, m_bit = 0, m_mode = 0, m_state = 0;
  int m_line = 0, m_ps = 0, m_und = 0;

  always #5 clk = ~clk;

  ucode_tx u_ucode_tx (
    .clk(clk), .rst(rst), .slot_en(slot_en), .mode_sel(mode_sel),
    .data_bit(data_bit), .data_valid(data_valid),
    .line_out(line_out), .bit_req(bit_req),
    .period_start(period_start), .underrun(underrun)
  );

  function automatic int shape(int mode, int s, int b, int st);
    case (mode)
      0: return b;
      1, 2: return st;
      3: return (b != 0 && s < 2) ? 1 : 0;
      4: return (b != 0) ? ((s == 2) ? 1 : 0) : ((s == 0) ? 1 : 0);
      5: return (b != 0) ? ((s <= 2) ? 1 : 0) : ((s == 0) ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int mode);
    case (mode)
      0: return "R2";
      1: return "R3/R11";
      2: return "R4/R11";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Model advances at each edge with the inputs that were stable before it.
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_slot = 3; m_bit = 0; m_mode = 0; m_state = 0;
      m_line = 0; m_ps = 0; m_und = 0;
    end else begin
      m_ps = 0;
      if (slot_en) begin
        if (m_slot == 3) begin
          m_slot = 0;
          m_bit  = (data_valid && data_bit) ? 1 : 0;
          if (!data_valid) m_und = 1;
          m_mode = int'(mode_sel);
          if (m_mode == 1 && m_bit == 1) m_state = 1 - m_state;
          if (m_mode == 2 && m_bit == 0) m_state = 1 - m_state;
          m_ps = 1;
        end else begin
          m_slot++;
        end
        m_line = shape(m_mode, m_slot, m_bit, m_state);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // One clock: compare registered outputs, drive new inputs, compare bit_req.
  task automatic step(bit en, int mode, bit d, bit v);
    @(negedge clk);
    if (!rst) begin
      check(tag_of(m_mode), int'(line_out), m_line);   // R12 line held between enables
      check("R9 period_start", int'(period_start), m_ps);
      check("R10 underrun", int'(underrun), m_und);
    end
    slot_en = en; mode_sel = 3'(mode); data_bit = d; data_valid = v;
    #1;
    if (!rst) check("R9 bit_req", int'(bit_req), (en && m_slot == 3) ? 1 : 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; slot_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; slot_en = 1'b0;
    #1;
    // R1: reset state
    check("R1 line_out", int'(line_out), 0);
    check("R1 period_start", int'(period_start), 0);
    check("R1 underrun", int'(underrun), 0);
    check("R1 bit_req idle", int'(bit_req), 0);
    slot_en = 1'b1;
    #1;
    check("R1 first request", int'(bit_req), 1);
    slot_en = 1'b0;
  endtask

  initial begin
    do_reset();
    // Each scheme alone, slot_en every clock (R2..R8)
    for (int md = 0; md < 8; md++) begin
      for (int k = 0; k < 48; k++) step(1'b1, md, 1'($urandom_range(1)), 1'b1);
    end
    // Scheme changes per period with irregular enables (R3, R4, R11, R12)
    for (int k = 0; k < 3000; k++) begin
      step(($urandom_range(2) == 0), (k / 9) % 6, 1'($urandom_range(1)), 1'b1);
    end
    // Toggle schemes interleaved with others at each bit (R11)
    for (int k = 0; k < 400; k++) begin
      int md;
      md = ((k / 4) % 2 == 0) ? 1 + ((k / 8) % 2) : 3 + ((k / 8) % 3);
      step(1'b1, md, 1'($urandom_range(1)), 1'b1);
    end
    // Missing bits force zero and raise the sticky flag (R10)
    for (int k = 0; k < 600; k++) begin
      step(1'b1, k % 6, 1'b1, ($urandom_range(5) != 0));
    end
    do_reset();
    check("R10 cleared by reset", int'(underrun), 0);
    for (int k = 0; k < 200; k++) step(1'b1, (k / 4) % 6, 1'($urandom_range(1)), 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule